// File: doc/BRIEF.md
# Peak-Current-Mode Symmetric Half-Bridge PWM

This block drives the two gates of a half-bridge under peak current control. A free-running counter defines the switching period. At each count of zero the high-side phase is switched on. It stays on until a trip pulse from an external current comparator arrives, which marks the moment the sensed current meets the compensation ramp. A maximum duty count acts as a backstop if no trip arrives in time.

The on-time that the comparator produced is measured in clocks. It is then replayed on the low-side phase starting at half period, so both phases carry equal widths in every cycle. Both phases then pass through dead-time insertion, which delays rising edges only. A fault override sits last and can force both gates low at any time.

The comparator pulse is handled as an action event ahead of dead-time insertion, not as a fault. A trip-terminated pulse therefore still receives dead time.

Top module: `pcm_sym_pwm`

## Requirements
- R1: The period counter runs 0, 1, …, P-1 and then returns to 0, where P is `period_i` (P ≥ 4). The high-side gate therefore rises once every P clocks in steady state.
- R2: In the clock after the counter reads 0, the high-side raw phase is set. With zero dead time, `gate_hi_o` is high while the counter reads 1 and above.
- R3: A trip pulse sampled while the counter reads k (k ≥ 1, high-side still on) clears the high-side phase. The high-side on-time is then exactly k clocks, and k is stored as the cycle's width.
- R4: Only the first trip in a cycle acts. Trip pulses after the clear, and any trip sampled while the counter reads 0, have no effect on either gate.
- R5: If no trip arrives, the high-side phase is cleared when the counter reaches L. L is `max_duty_i` clamped into the range 1 to P/2-1 (integer halving).
- R6: The low-side raw phase is set in the clock after the counter reads P/2. It stays high for exactly the width stored in R3/R5 for the same cycle.
- R7: Each gate's rising edge is delayed by `db_count_i` clocks, and its falling edge is not delayed. A raw pulse no longer than the dead time produces no gate pulse.
- R8: `gate_hi_o` and `gate_lo_o` are never high in the same clock.
- R9: While `tz_fault_i` is high, both gates are low in that same clock, with no register in the path.
- R10: After `tz_fault_i` falls, both gates stay low until the clock edge at which the counter reads 0 with the fault low. Normal switching resumes from that cycle.
- R11: During and right after synchronous reset, both gates are low and the counter restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | CNT_W | Switching period in clocks (≥ 4) |
| max_duty_i | input | CNT_W | Maximum high-side on-time in clocks before clamping |
| cmp_trip_i | input | 1 | Comparator trip event, synchronous to clk |
| db_count_i | input | DB_W | Dead time in clocks applied to rising edges |
| tz_fault_i | input | 1 | Fault override, forces both gates low |
| gate_hi_o | output | 1 | High-side gate drive |
| gate_lo_o | output | 1 | Low-side gate drive |

## Verification
A wrong counter or set/clear state appears at `gate_hi_o` within one period, as a shifted rise or a pulse of the wrong length. A stale or miscaptured width appears on `gate_lo_o` later in the same period, as a low-side pulse whose length differs from the high-side one. A fault latch that clears early or late shows as a gate pulse inside the lockout window, or as a missing one after the next count of zero. The bench compares both gates with a behavioural model on every clock, so any of these is reported in the first clock it shows.

// File: rtl/pcm_pwm_pkg.sv
package pcm_pwm_pkg;

    typedef enum logic [1:0] {
        AQ_HOLD      = 2'd0,
        AQ_SET       = 2'd1,
        AQ_TRIP_CLR  = 2'd2,
        AQ_LIMIT_CLR = 2'd3
    } aq_act_e;

    typedef struct packed {
        logic lo;
        logic hi;
    } phase_pair_t;

    localparam int NUM_PHASES = 2;

    // Clamp the requested on-time into 1 .. period/2-1.
    function automatic int duty_limit(int max_duty, int period);
        int top;
        top = (period / 2) - 1;
        if (top < 1) top = 1;
        if (max_duty < 1) return 1;
        if (max_duty > top) return top;
        return max_duty;
    endfunction

endpackage

// File: rtl/pcm_period_ctr.sv
module pcm_period_ctr #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] ctr_o,
    output logic             zero_o,
    output logic [CNT_W-1:0] half_o
);
    logic [CNT_W-1:0] ctr_q;
    logic [CNT_W-1:0] last_val;

    assign last_val = period_i - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_q <= '0;
        end else if (ctr_q >= last_val) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_q + 1'b1;
        end
    end

    assign ctr_o  = ctr_q;
    assign zero_o = (ctr_q == '0);
    assign half_o = period_i >> 1;

    assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (ctr_q >= last_val) |=> (ctr_q == '0))
        else $error("counter did not wrap");

endmodule

// File: rtl/pcm_action_qual.sv
module pcm_action_qual
    import pcm_pwm_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] ctr_i,
    input  logic             zero_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] max_duty_i,
    input  logic             cmp_trip_i,
    output logic             hs_o,
    output logic [CNT_W-1:0] width_o,
    output logic             width_vld_o
);
    logic             hs_q;
    logic             armed_q;
    logic [CNT_W-1:0] width_q;
    logic             vld_q;
    logic [CNT_W-1:0] lim;
    aq_act_e          act;

    assign lim = CNT_W'(duty_limit(int'(max_duty_i), int'(period_i)));

    always_comb begin
        act = AQ_HOLD;
        if (zero_i) begin
            act = AQ_SET;
        end else if (armed_q && hs_q && cmp_trip_i) begin
            act = AQ_TRIP_CLR;
        end else if (armed_q && hs_q && (ctr_i >= lim)) begin
            act = AQ_LIMIT_CLR;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q    <= 1'b0;
            armed_q <= 1'b0;
            width_q <= '0;
            vld_q   <= 1'b0;
        end else begin
            case (act)
                AQ_SET: begin
                    hs_q    <= 1'b1;
                    armed_q <= 1'b1;
                end
                AQ_TRIP_CLR, AQ_LIMIT_CLR: begin
                    hs_q    <= 1'b0;
                    armed_q <= 1'b0;
                    width_q <= ctr_i;
                    vld_q   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign hs_o        = hs_q;
    assign width_o     = width_q;
    assign width_vld_o = vld_q;

    assert_set_at_zero_R2: assert property (@(posedge clk) disable iff (rst)
        zero_i |=> hs_q)
        else $error("high side not set after zero");

    assert_trip_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (hs_q && armed_q && cmp_trip_i && !zero_i) |=> (!hs_q && width_q == $past(ctr_i)))
        else $error("trip did not clear or capture");

    assert_stay_low_R4: assert property (@(posedge clk) disable iff (rst)
        (!hs_q && !zero_i) |=> !hs_q)
        else $error("high side re-set inside cycle");

    assert_width_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
        vld_q |-> (width_q != '0))
        else $error("zero width captured");

endmodule

// File: rtl/pcm_pulse_replay.sv
module pcm_pulse_replay #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] ctr_i,
    input  logic             zero_i,
    input  logic [CNT_W-1:0] half_i,
    input  logic [CNT_W-1:0] width_i,
    input  logic             width_vld_i,
    output logic             lo_o
);
    logic           lo_q;
    logic [CNT_W:0] end_cnt;
    logic           start_hit;

    assign end_cnt   = {1'b0, half_i} + {1'b0, width_i};
    assign start_hit = (ctr_i == half_i) && width_vld_i && (width_i != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= 1'b0;
        end else if (zero_i) begin
            lo_q <= 1'b0;
        end else if (start_hit) begin
            lo_q <= 1'b1;
        end else if (lo_q && ({1'b0, ctr_i} >= end_cnt)) begin
            lo_q <= 1'b0;
        end
    end

    assign lo_o = lo_q;

    assert_lo_start_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(lo_q) |-> ($past(ctr_i) == $past(half_i)))
        else $error("low side started off half period");

endmodule

// File: rtl/pcm_deadband.sv
module pcm_deadband #(
    parameter int DB_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            raw_i,
    input  logic [DB_W-1:0] db_i,
    output logic            out_o
);
    logic [DB_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!raw_i) begin
            cnt_q <= '0;
        end else if (cnt_q < db_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign out_o = raw_i && (cnt_q >= db_i);

    assert_rise_delayed_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(raw_i) && db_i != '0) |-> !out_o)
        else $error("rising edge not delayed");

    assert_fall_immediate_R7: assert property (@(posedge clk) disable iff (rst)
        !raw_i |-> !out_o)
        else $error("falling edge delayed");

endmodule

// File: rtl/pcm_sym_pwm.sv
module pcm_sym_pwm
    import pcm_pwm_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int DB_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] max_duty_i,
    input  logic             cmp_trip_i,
    input  logic [DB_W-1:0]  db_count_i,
    input  logic             tz_fault_i,
    output logic             gate_hi_o,
    output logic             gate_lo_o
);
    logic [CNT_W-1:0] ctr;
    logic             ctr_zero;
    logic [CNT_W-1:0] half_val;
    logic [CNT_W-1:0] width;
    logic             width_vld;
    phase_pair_t      raw_pair;
    logic [NUM_PHASES-1:0] raw_vec;
    logic [NUM_PHASES-1:0] dly_vec;
    logic             tz_hold_q;
    logic             block;

    pcm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .period_i (period_i),
        .ctr_o    (ctr),
        .zero_o   (ctr_zero),
        .half_o   (half_val)
    );

    pcm_action_qual #(.CNT_W(CNT_W)) u_aq (
        .clk         (clk),
        .rst         (rst),
        .ctr_i       (ctr),
        .zero_i      (ctr_zero),
        .period_i    (period_i),
        .max_duty_i  (max_duty_i),
        .cmp_trip_i  (cmp_trip_i),
        .hs_o        (raw_pair.hi),
        .width_o     (width),
        .width_vld_o (width_vld)
    );

    pcm_pulse_replay #(.CNT_W(CNT_W)) u_replay (
        .clk         (clk),
        .rst         (rst),
        .ctr_i       (ctr),
        .zero_i      (ctr_zero),
        .half_i      (half_val),
        .width_i     (width),
        .width_vld_i (width_vld),
        .lo_o        (raw_pair.lo)
    );

    assign raw_vec = raw_pair;

    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_db
        pcm_deadband #(.DB_W(DB_W)) u_db (
            .clk   (clk),
            .rst   (rst),
            .raw_i (raw_vec[g]),
            .db_i  (db_count_i),
            .out_o (dly_vec[g])
        );
    end

    // Fault lockout: set by the fault, released only at a counter zero.
    always_ff @(posedge clk) begin
        if (rst) begin
            tz_hold_q <= 1'b0;
        end else if (tz_fault_i) begin
            tz_hold_q <= 1'b1;
        end else if (ctr_zero) begin
            tz_hold_q <= 1'b0;
        end
    end

    assign block     = tz_fault_i | tz_hold_q;
    assign gate_hi_o = dly_vec[0] & ~block;
    assign gate_lo_o = dly_vec[1] & ~block & ~dly_vec[0];

    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (rst)
        !(gate_hi_o && gate_lo_o))
        else $error("both gates high");

    assert_tz_low_R9: assert property (@(posedge clk) disable iff (rst)
        tz_fault_i |-> (!gate_hi_o && !gate_lo_o))
        else $error("fault did not force low");

    assert_tz_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (tz_hold_q && !ctr_zero) |=> (tz_hold_q && !gate_hi_o && !gate_lo_o))
        else $error("lockout released early");

    assert_reset_R11: assert property (@(posedge clk)
        rst |=> (!gate_hi_o && !gate_lo_o))
        else $error("gates high after reset");

endmodule

// File: tb/tb_pcm_sym_pwm.sv
module tb_pcm_sym_pwm;
    localparam int CNT_W = 12;
    localparam int DB_W  = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CNT_W-1:0] period_i = 12'd40;
    logic [CNT_W-1:0] max_duty_i = 12'd30;
    logic             cmp_trip_i = 1'b0;
    logic [DB_W-1:0]  db_count_i = '0;
    logic             tz_fault_i = 1'b0;
    logic             gate_hi_o;
    logic             gate_lo_o;

    pcm_sym_pwm #(.CNT_W(CNT_W), .DB_W(DB_W)) dut (
        .clk        (clk),
        .rst        (rst),
        .period_i   (period_i),
        .max_duty_i (max_duty_i),
        .cmp_trip_i (cmp_trip_i),
        .db_count_i (db_count_i),
        .tz_fault_i (tz_fault_i),
        .gate_hi_o  (gate_hi_o),
        .gate_lo_o  (gate_lo_o)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string cur_req = "R11";

    // stimulus controls
    int trip_at = -1;
    int trip2_at = -1;
    bit trip_on_zero = 0;

    // reference model state
    int m_ctr = 0, m_width = 0, m_hage = 0, m_lage = 0;
    bit m_hs = 0, m_armed = 0, m_lo = 0, m_tz = 0;

    // pulse measurement
    int hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0;
    int last_rise = -1, rise_gap = 0;
    bit prev_hi = 0;

    function automatic int clampv(int md, int p);
        int top;
        top = p / 2 - 1;
        if (top < 1) top = 1;
        if (md < 1) return 1;
        if (md > top) return top;
        return md;
    endfunction

    always @(posedge clk) begin
        int half, lim;
        int n_ctr, n_width, n_hage, n_lage;
        bit n_hs, n_armed, n_lo, n_tz;
        cyc++;
        if (rst) begin
            m_ctr = 0; m_width = 0; m_hage = 0; m_lage = 0;
            m_hs = 0; m_armed = 0; m_lo = 0; m_tz = 0;
        end else begin
            half = int'(period_i) / 2;
            lim  = clampv(int'(max_duty_i), int'(period_i));
            n_hs = m_hs; n_armed = m_armed; n_width = m_width; n_lo = m_lo;
            n_hage = m_hs ? ((m_hage < 1000) ? m_hage + 1 : m_hage) : 0;
            n_lage = m_lo ? ((m_lage < 1000) ? m_lage + 1 : m_lage) : 0;
            if (tz_fault_i) n_tz = 1;
            else if (m_ctr == 0) n_tz = 0;
            else n_tz = m_tz;
            if (m_ctr == 0) begin
                n_hs = 1; n_armed = 1;
            end else if (m_armed && m_hs && (cmp_trip_i || m_ctr >= lim)) begin
                n_hs = 0; n_armed = 0; n_width = m_ctr;
            end
            if (m_ctr == 0) n_lo = 0;
            else if (m_ctr == half && m_width > 0) n_lo = 1;
            else if (m_lo && m_ctr >= half + m_width) n_lo = 0;
            n_ctr = (m_ctr >= int'(period_i) - 1) ? 0 : m_ctr + 1;
            m_ctr = n_ctr; m_width = n_width; m_hage = n_hage; m_lage = n_lage;
            m_hs = n_hs; m_armed = n_armed; m_lo = n_lo; m_tz = n_tz;
        end
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog expired act=%0d exp=<50000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    // One clock: compare at the falling edge, then drive the next inputs.
    task automatic step();
        bit e_hi, e_lo, blk, hdb, ldb;
        @(negedge clk);
        blk = tz_fault_i || m_tz;
        hdb = m_hs && (m_hage >= int'(db_count_i));
        ldb = m_lo && (m_lage >= int'(db_count_i));
        e_hi = rst ? 0 : (hdb && !blk);
        e_lo = rst ? 0 : (ldb && !blk && !hdb);
        chk(gate_hi_o == e_hi, cur_req, "gate_hi_o", int'(gate_hi_o), int'(e_hi));
        chk(gate_lo_o == e_lo, cur_req, "gate_lo_o", int'(gate_lo_o), int'(e_lo));
        chk(!(gate_hi_o && gate_lo_o), "R8", "overlap", 1, 0);
        if (gate_hi_o) hi_run++;
        else if (hi_run > 0) begin last_hi = hi_run; hi_run = 0; end
        if (gate_lo_o) lo_run++;
        else if (lo_run > 0) begin last_lo = lo_run; lo_run = 0; end
        if (gate_hi_o && !prev_hi) begin
            if (last_rise >= 0) rise_gap = cyc - last_rise;
            last_rise = cyc;
        end
        prev_hi = gate_hi_o;
        cmp_trip_i = (m_ctr == trip_at) || (m_ctr == trip2_at) ||
                     (trip_on_zero && m_ctr == 0);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        // R11: reset state
        cur_req = "R11";
        run(3);
        chk(!gate_hi_o && !gate_lo_o, "R11", "gates low in reset", int'(gate_hi_o | gate_lo_o), 0);
        @(negedge clk); rst = 1'b0;
        run(2);

        // R2/R3/R1/R6: basic trip-terminated cycles
        cur_req = "R3"; trip_at = 7;
        run(130);
        chk(last_hi == 7, "R3", "high-side width", last_hi, 7);
        chk(last_lo == 7, "R6", "low-side width", last_lo, 7);
        chk(rise_gap == 40, "R1", "rise spacing", rise_gap, 40);
        cur_req = "R2";
        run(40);

        // R4: extra trips and a trip at zero are ignored
        cur_req = "R4"; trip_at = 5; trip2_at = 9; trip_on_zero = 1;
        run(90);
        chk(last_hi == 5, "R4", "only first trip acts", last_hi, 5);
        chk(last_lo == 5, "R4", "low side follows first trip", last_lo, 5);
        trip2_at = -1; trip_on_zero = 0;

        // R5: max duty backstop and clamping
        cur_req = "R5"; trip_at = -1; max_duty_i = 12'd12;
        run(90);
        chk(last_hi == 12, "R5", "limit 12", last_hi, 12);
        max_duty_i = 12'd30;
        run(90);
        chk(last_hi == 19, "R5", "clamp high", last_hi, 19);
        chk(last_lo == 19, "R6", "clamped width replayed", last_lo, 19);
        max_duty_i = 12'd0;
        run(90);
        chk(last_hi == 1, "R5", "clamp low", last_hi, 1);
        max_duty_i = 12'd30;

        // R6: widths tracked as the trip point moves
        cur_req = "R6"; trip_at = 11;
        run(90);
        chk(last_lo == 11, "R6", "low width 11", last_lo, 11);
        trip_at = 3;
        run(90);
        chk(last_lo == 3, "R6", "low width 3", last_lo, 3);

        // R1: shorter period
        cur_req = "R1"; period_i = 12'd16; trip_at = 4;
        run(70);
        chk(rise_gap == 16, "R1", "rise spacing 16", rise_gap, 16);
        period_i = 12'd40;
        run(50);

        // R7: dead time
        cur_req = "R7"; trip_at = 10; db_count_i = 8'd3;
        run(90);
        chk(last_hi == 7, "R7", "high width after dead time", last_hi, 7);
        chk(last_lo == 7, "R7", "low width after dead time", last_lo, 7);
        db_count_i = 8'd15;
        run(90);
        db_count_i = 8'd0;
        run(45);

        // R9/R10: fault override and lockout until counter zero
        cur_req = "R9";
        while (m_ctr != 3) step();
        tz_fault_i = 1'b1;
        #1;
        chk(!gate_hi_o, "R9", "immediate force low", int'(gate_hi_o), 0);
        run(5);
        cur_req = "R10"; tz_fault_i = 1'b0;
        run(20);
        chk(!gate_hi_o && !gate_lo_o, "R10", "held low before zero", int'(gate_hi_o | gate_lo_o), 0);
        run(60);
        chk(last_hi == 10, "R10", "switching resumes", last_hi, 10);

        // R11: reset mid-run
        cur_req = "R11";
        while (m_ctr != 4) step();
        rst = 1'b1;
        run(2);
        chk(!gate_hi_o && !gate_lo_o, "R11", "gates low after reset", int'(gate_hi_o | gate_lo_o), 0);
        rst = 1'b0;
        run(90);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule